// File: doc/BRIEF.md
# UART Channel Interrupt Controller

This block drives the single interrupt line of one UART channel and presents an encoded identification of the most urgent pending cause. It holds the channel's 8-bit interrupt enable register, written over a simple write strobe and data bus. It also collects status from the rest of the channel: received data available or the receive FIFO trigger reached, transmit holding register empty or the transmit FIFO below its trigger, line error flags, a modem status change, a received Xoff character, and the level of the RTS output pin.

Three of the upper enable bits control sleep, the received-Xoff interrupt and the RTS interrupt. They can only be written, and only take effect, while the enhanced-feature input is high. Two sources are latched inside the block. The transmit-ready source is one: it arms on a new empty or below-trigger condition, and it also arms when its enable bit goes from 0 to 1 while that condition already holds. The RTS rising edge is the other. The host clears either source by reading the identification code while that source is the one reported, and writing the transmit holding register also clears the transmit source. With enable bits 0 to 3 clear, the channel works in polled mode and the interrupt line stays low.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq` is 0 and `irq_id` is 4'h1 (nothing pending).
- R2: A write (`ier_wr` = 1) always loads bits 3..0 of `ier_wdata` into `ier_q[3:0]`, and `ier_q[7]` always reads 0.
- R3: Bits 6..4 of `ier_q` (sleep, Xoff, RTS enables) are loaded only by a write made while `enh_en` = 1; otherwise they keep their value. Bits 6 and 5 gate their sources only while `enh_en` = 1.
- R4: The receive source is `rx_avail` when `fifo_mode` = 0 and `rx_trig` when `fifo_mode` = 1, gated by enable bit 0. It reports code 4'h4.
- R5: The transmit condition is `thr_empty` when `fifo_mode` = 0 and `tx_below` when `fifo_mode` = 1. A 0-to-1 change of that condition arms the transmit source, which is gated by enable bit 1 and reports code 4'h2.
- R6: A write that changes enable bit 1 from 0 to 1 while the transmit condition is already true arms the transmit source, with no new transition needed.
- R7: The armed transmit source is cleared by `thr_wr`, by `id_rd` while `irq_id` is 4'h2, or when the transmit condition goes false.
- R8: The line-status source is active while any bit of `lsr_err` (bit 0 overrun, bits 1..3 parity, framing, break) is 1. It is gated by enable bit 2 and reports code 4'h6.
- R9: `msr_change` gated by enable bit 3 reports code 4'h0. `xoff_rcvd` gated by enable bit 5 and `enh_en` reports code 4'h8.
- R10: A 0-to-1 change of `rts_out` latches the RTS source. It is gated by enable bit 6 and `enh_en`, reports code 4'hA, and is cleared only by `id_rd` while `irq_id` is 4'hA.
- R11: When several enabled sources are active, `irq_id` reports them in this priority order: line status, receive, transmit, modem, Xoff, RTS.
- R12: `irq` is 1 exactly when `irq_id` is not 4'h1. Both are registered and change on the clock edge that samples the causing state.
- R13: With enable bits 0..3 clear and the gated upper bits inactive, `irq` stays 0 whatever the status inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced-feature bit; unlocks enable bits 6..4 |
| fifo_mode | input | 1 | 1 selects the FIFO trigger forms of the receive and transmit sources |
| rx_avail | input | 1 | Receive holding register holds a character |
| rx_trig | input | 1 | Receive FIFO at or above its trigger level |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_below | input | 1 | Transmit FIFO below its trigger level |
| lsr_err | input | 4 | Line error flags: overrun, parity, framing, break |
| msr_change | input | 1 | Modem status change pending |
| xoff_rcvd | input | 1 | Xoff character received |
| rts_out | input | 1 | Level of the RTS output pin |
| thr_wr | input | 1 | Host write of the transmit holding register |
| id_rd | input | 1 | Host read of the identification code |
| ier_q | output | 8 | Enable register contents |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Code of the highest-priority enabled pending source |

## Verification
A level source (line, receive, modem, Xoff) shows on `irq` and `irq_id` one clock edge after the bench applies it. An enable-register write shows on `ier_q` after one edge and on the interrupt after two. The latched transmit and RTS sources need two edges: one to latch the source, one to register the output. A clear by `id_rd` or `thr_wr` also takes two edges to reach the output. The bench drives inputs on the falling edge and counts exactly these edges before each directed check. On every falling edge it also compares the outputs with a behavioural model that is advanced on the rising edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int SRC_N = 6;
   localparam int ID_W  = 4;

   // priority slots, index 0 is the most urgent
   localparam int P_LINE  = 0;
   localparam int P_RX    = 1;
   localparam int P_TX    = 2;
   localparam int P_MODEM = 3;
   localparam int P_XOFF  = 4;
   localparam int P_RTS   = 5;

   // enable register bit positions
   localparam int EB_RX    = 0;
   localparam int EB_TX    = 1;
   localparam int EB_LINE  = 2;
   localparam int EB_MODEM = 3;
   localparam int EB_SLEEP = 4;
   localparam int EB_XOFF  = 5;
   localparam int EB_RTS   = 6;

   localparam logic [ID_W-1:0] ID_NONE  = 4'h1;
   localparam logic [ID_W-1:0] ID_LINE  = 4'h6;
   localparam logic [ID_W-1:0] ID_RX    = 4'h4;
   localparam logic [ID_W-1:0] ID_TX    = 4'h2;
   localparam logic [ID_W-1:0] ID_MODEM = 4'h0;
   localparam logic [ID_W-1:0] ID_XOFF  = 4'h8;
   localparam logic [ID_W-1:0] ID_RTS   = 4'hA;

   function automatic logic [ID_W-1:0] slot_code(input int slot);
      case (slot)
         P_LINE:  slot_code = ID_LINE;
         P_RX:    slot_code = ID_RX;
         P_TX:    slot_code = ID_TX;
         P_MODEM: slot_code = ID_MODEM;
         P_XOFF:  slot_code = ID_XOFF;
         P_RTS:   slot_code = ID_RTS;
         default: slot_code = ID_NONE;
      endcase
   endfunction
endpackage

// File: rtl/uic_enable_reg.sv
module uic_enable_reg
   import uart_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              enh_en,
   output logic [DATA_W-1:0] en_q,
   output logic              arm_tx
);
   localparam int LOW_TOP = EB_MODEM;
   localparam int UP_LO   = EB_SLEEP;
   localparam int UP_HI   = EB_RTS;

   if (DATA_W < UP_HI + 2) begin : g_bad_width
      $error("uic_enable_reg: DATA_W too small for the enable layout");
   end

   logic [DATA_W-1:0] en_nxt;

   always_comb begin
      en_nxt = en_q;
      if (wr) begin
         en_nxt[LOW_TOP:0] = wdata[LOW_TOP:0];
         if (enh_en) en_nxt[UP_HI:UP_LO] = wdata[UP_HI:UP_LO];
      end
      en_nxt[DATA_W-1:UP_HI+1] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_nxt;
   end

   assign arm_tx = wr & wdata[EB_TX] & ~en_q[EB_TX];

   AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> en_q[LOW_TOP:0] == $past(wdata[LOW_TOP:0])); // R2
   AST_UPPER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_en |=> en_q[UP_HI:UP_LO] == $past(en_q[UP_HI:UP_LO])); // R3
endmodule

// File: rtl/uic_sources.sv
module uic_sources
   import uart_irq_pkg::*;
#(
   parameter int LSR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode,
   input  logic             rx_avail,
   input  logic             rx_trig,
   input  logic             thr_empty,
   input  logic             tx_below,
   input  logic [LSR_W-1:0] lsr_err,
   input  logic             msr_change,
   input  logic             xoff_rcvd,
   input  logic             rts_out,
   input  logic             arm_tx,
   input  logic             thr_wr,
   input  logic             id_rd,
   input  logic             tx_reported,
   input  logic             rts_reported,
   output logic [SRC_N-1:0] pend
);
   if (LSR_W < 1) begin : g_bad_lsr
      $error("uic_sources: LSR_W must be at least 1");
   end

   logic tx_cond, tx_cond_q, tx_pend, tx_set, tx_clr;
   logic rts_q, rts_pend, rts_rise;
   logic rx_src;

   assign tx_cond  = fifo_mode ? tx_below : thr_empty;
   assign rx_src   = fifo_mode ? rx_trig  : rx_avail;
   assign tx_set   = tx_cond & (~tx_cond_q | arm_tx);
   assign tx_clr   = thr_wr | (id_rd & tx_reported);
   assign rts_rise = rts_out & ~rts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_cond_q <= 1'b0;
         tx_pend   <= 1'b0;
         rts_q     <= 1'b0;
         rts_pend  <= 1'b0;
      end else begin
         tx_cond_q <= tx_cond;
         rts_q     <= rts_out;
         if (!tx_cond)    tx_pend <= 1'b0;
         else if (tx_set) tx_pend <= 1'b1;
         else if (tx_clr) tx_pend <= 1'b0;
         if (rts_rise)                   rts_pend <= 1'b1;
         else if (id_rd && rts_reported) rts_pend <= 1'b0;
      end
   end

   always_comb begin
      pend          = '0;
      pend[P_LINE]  = |lsr_err;
      pend[P_RX]    = rx_src;
      pend[P_TX]    = tx_pend;
      pend[P_MODEM] = msr_change;
      pend[P_XOFF]  = xoff_rcvd;
      pend[P_RTS]   = rts_pend;
   end

   AST_TX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_tx && tx_cond) |=> tx_pend); // R6
   AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && tx_cond_q && !arm_tx) |=> !tx_pend); // R7
   AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_pend && !id_rd) |=> rts_pend); // R10
endmodule

// File: rtl/uic_prioritizer.sv
module uic_prioritizer
   import uart_irq_pkg::*;
(
   input  logic [SRC_N-1:0] act,
   output logic [ID_W-1:0]  id
);
   always_comb begin
      id = ID_NONE;
      for (int i = SRC_N - 1; i >= 0; i--) begin
         if (act[i]) id = slot_code(i);
      end
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int LSR_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ier_wr,
   input  logic [DATA_W-1:0] ier_wdata,
   input  logic              enh_en,
   input  logic              fifo_mode,
   input  logic              rx_avail,
   input  logic              rx_trig,
   input  logic              thr_empty,
   input  logic              tx_below,
   input  logic [LSR_W-1:0]  lsr_err,
   input  logic              msr_change,
   input  logic              xoff_rcvd,
   input  logic              rts_out,
   input  logic              thr_wr,
   input  logic              id_rd,
   output logic [DATA_W-1:0] ier_q,
   output logic              irq,
   output logic [ID_W-1:0]   irq_id
);
   logic              arm_tx;
   logic [SRC_N-1:0]  pend, act, gate;
   logic [ID_W-1:0]   id_nxt;

   uic_enable_reg #(.DATA_W(DATA_W)) u_en (
      .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
      .enh_en(enh_en), .en_q(ier_q), .arm_tx(arm_tx)
   );

   uic_sources #(.LSR_W(LSR_W)) u_src (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
      .rx_avail(rx_avail), .rx_trig(rx_trig),
      .thr_empty(thr_empty), .tx_below(tx_below),
      .lsr_err(lsr_err), .msr_change(msr_change), .xoff_rcvd(xoff_rcvd),
      .rts_out(rts_out), .arm_tx(arm_tx), .thr_wr(thr_wr), .id_rd(id_rd),
      .tx_reported(irq_id == ID_TX), .rts_reported(irq_id == ID_RTS),
      .pend(pend)
   );

   always_comb begin
      gate          = '0;
      gate[P_LINE]  = ier_q[EB_LINE];
      gate[P_RX]    = ier_q[EB_RX];
      gate[P_TX]    = ier_q[EB_TX];
      gate[P_MODEM] = ier_q[EB_MODEM];
      gate[P_XOFF]  = ier_q[EB_XOFF] & enh_en;
      gate[P_RTS]   = ier_q[EB_RTS]  & enh_en;
   end

   assign act = pend & gate;

   uic_prioritizer u_pri (.act(act), .id(id_nxt));

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq    <= 1'b0;
            irq_id <= ID_NONE;
         end else begin
            irq    <= (id_nxt != ID_NONE);
            irq_id <= id_nxt;
         end
      end

      AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         (ier_q[EB_LINE] && (|lsr_err)) |=> irq_id == ID_LINE); // R11
      AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (ier_q[EB_MODEM:0] == '0 && (!enh_en || ier_q[EB_RTS:EB_XOFF] == '0))
         |=> !irq); // R13
   end else begin : g_comb_out
      assign irq    = (id_nxt != ID_NONE);
      assign irq_id = id_nxt;
   end

   AST_FLAG_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_id != ID_NONE); // R12
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ier_wr = 0, enh_en = 0, fifo_mode = 0;
   logic [7:0] ier_wdata = 0;
   logic       rx_avail = 0, rx_trig = 0, thr_empty = 0, tx_below = 0;
   logic [3:0] lsr_err = 0;
   logic       msr_change = 0, xoff_rcvd = 0, rts_out = 0, thr_wr = 0, id_rd = 0;
   logic [7:0] ier_q;
   logic       irq;
   logic [3:0] irq_id;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .enh_en(enh_en), .fifo_mode(fifo_mode), .rx_avail(rx_avail),
      .rx_trig(rx_trig), .thr_empty(thr_empty), .tx_below(tx_below),
      .lsr_err(lsr_err), .msr_change(msr_change), .xoff_rcvd(xoff_rcvd),
      .rts_out(rts_out), .thr_wr(thr_wr), .id_rd(id_rd),
      .ier_q(ier_q), .irq(irq), .irq_id(irq_id)
   );

   // behavioural reference, advanced on the rising edge
   int m_en, m_txp, m_txc_prev, m_rtsp, m_rts_prev, exp_irq, exp_id;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_txp = 0; m_txc_prev = 0; m_rtsp = 0; m_rts_prev = 0;
         exp_irq = 0; exp_id = 1;
      end else begin
         int txc, n_txp, n_rtsp, n_en, n_id;
         int codes[$];
         bit on[$];
         txc = fifo_mode ? int'(tx_below) : int'(thr_empty);
         n_txp = m_txp;
         if (!txc) n_txp = 0;
         else if (!m_txc_prev || (ier_wr && ier_wdata[1] && !m_en[1])) n_txp = 1;
         else if (thr_wr || (id_rd && exp_id == 2)) n_txp = 0;
         n_rtsp = m_rtsp;
         if (rts_out && !m_rts_prev) n_rtsp = 1;
         else if (id_rd && exp_id == 10) n_rtsp = 0;
         codes = '{6, 4, 2, 0, 8, 10};
         on = '{m_en[2] && lsr_err != 0,
                m_en[0] && (fifo_mode ? rx_trig : rx_avail),
                m_en[1] && m_txp != 0,
                m_en[3] && msr_change,
                m_en[5] && enh_en && xoff_rcvd,
                m_en[6] && enh_en && m_rtsp != 0};
         n_id = 1;
         foreach (on[k]) if (on[k] && n_id == 1) n_id = codes[k];
         n_en = m_en;
         if (ier_wr) begin
            n_en = (n_en & 'h70) | (ier_wdata & 'h0F);
            if (enh_en) n_en = (n_en & 'h0F) | (ier_wdata & 'h70);
         end
         exp_id = n_id; exp_irq = (n_id != 1);
         m_en = n_en; m_txp = n_txp; m_txc_prev = txc;
         m_rtsp = n_rtsp; m_rts_prev = rts_out;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq !== exp_irq[0] || irq_id !== exp_id[3:0] || ier_q !== m_en[7:0]) begin
            errors++;
            $display("FAIL R12 model: irq=%0d id=%h ier=%h expected irq=%0d id=%h ier=%h",
                     irq, irq_id, ier_q, exp_irq, exp_id, m_en);
         end
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_en(input logic [7:0] v);
      ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0; ier_wdata = 0;
   endtask

   task automatic pulse_rd();
      id_rd = 1; tick(); id_rd = 0;
   endtask

   task automatic pulse_thr();
      thr_wr = 1; tick(); thr_wr = 0;
   endtask

   task automatic quiet();
      rx_avail = 0; rx_trig = 0; thr_empty = 0; tx_below = 0; lsr_err = 0;
      msr_change = 0; xoff_rcvd = 0; rts_out = 0; fifo_mode = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(ier_q == 8'h00, "R1 ier", ier_q, 0);
      chk(irq == 0, "R1 irq", irq, 0);
      chk(irq_id == 4'h1, "R1 id", irq_id, 1);

      // R13 polled: everything active, no enables
      lsr_err = 4'hF; rx_avail = 1; thr_empty = 1; msr_change = 1; xoff_rcvd = 1;
      tick(2);
      chk(irq == 0, "R13 polled", irq, 0);
      quiet(); tick();

      // R2 / R3 write gating
      enh_en = 1; wr_en(8'h70);
      chk(ier_q == 8'h70, "R3 unlocked write", ier_q, 8'h70);
      enh_en = 0; wr_en(8'h8F);
      chk(ier_q == 8'h7F, "R2 low bits and bit7", ier_q, 8'h7F);
      wr_en(8'h00);
      chk(ier_q == 8'h70, "R3 locked upper", ier_q, 8'h70);
      enh_en = 1; wr_en(8'h00); enh_en = 0;
      chk(ier_q == 8'h00, "R3 clear upper", ier_q, 0);

      // R4 receive source selection
      wr_en(8'h01); tick();
      rx_avail = 1; tick();
      chk(irq_id == 4'h4, "R4 non-FIFO", irq_id, 4);
      rx_avail = 0; fifo_mode = 1; rx_trig = 1; tick();
      chk(irq_id == 4'h4, "R4 FIFO trigger", irq_id, 4);
      rx_avail = 1; rx_trig = 0; tick();
      chk(irq == 0, "R4 avail ignored in FIFO mode", irq, 0);
      quiet(); tick();

      // R6 enabling transmit while already empty
      wr_en(8'h00);
      thr_empty = 1; tick(2);
      chk(irq == 0, "R6 disabled", irq, 0);
      pulse_thr(); tick();
      wr_en(8'h02); tick();
      chk(irq_id == 4'h2, "R6 arm on enable", irq_id, 2);
      // R7 clear by identification read
      pulse_rd(); tick();
      chk(irq == 0, "R7 read clears", irq, 0);
      quiet(); tick();

      // R5 FIFO below-trigger edge, R7 clear by holding write
      fifo_mode = 1; tx_below = 1; tick(2);
      chk(irq_id == 4'h2, "R5 below trigger", irq_id, 2);
      pulse_thr(); tick();
      chk(irq == 0, "R7 holding write clears", irq, 0);
      quiet(); tick();

      // R8 line status bits each
      wr_en(8'h04); tick();
      for (int b = 0; b < 4; b++) begin
         lsr_err = 4'(1 << b); tick();
         chk(irq_id == 4'h6, "R8 line bit", irq_id, 6);
      end
      wr_en(8'h00); tick();
      chk(irq == 0, "R8 gated", irq, 0);
      quiet(); tick();

      // R9 modem and Xoff
      wr_en(8'h08); msr_change = 1; tick(2);
      chk(irq == 1 && irq_id == 4'h0, "R9 modem", irq_id, 0);
      msr_change = 0; enh_en = 1; wr_en(8'h20); xoff_rcvd = 1; tick(2);
      chk(irq_id == 4'h8, "R9 xoff", irq_id, 8);
      enh_en = 0; tick();
      chk(irq == 0, "R3 gated without enhanced", irq, 0);
      quiet(); tick();

      // R10 RTS edge
      enh_en = 1; wr_en(8'h40); tick();
      rts_out = 1; tick(2);
      chk(irq_id == 4'hA, "R10 rts rise", irq_id, 10);
      tick(3);
      chk(irq_id == 4'hA, "R10 latched", irq_id, 10);
      pulse_rd(); tick(2);
      chk(irq == 0, "R10 read clears", irq, 0);
      quiet(); tick();

      // R11 priority walk
      wr_en(8'h6F); tick();
      lsr_err = 4'h2; rx_avail = 1; thr_empty = 1; msr_change = 1;
      xoff_rcvd = 1; rts_out = 1; tick(2);
      chk(irq_id == 4'h6, "R11 line first", irq_id, 6);
      lsr_err = 0; tick();
      chk(irq_id == 4'h4, "R11 receive next", irq_id, 4);
      rx_avail = 0; tick();
      chk(irq_id == 4'h2, "R11 transmit next", irq_id, 2);
      pulse_thr(); tick();
      chk(irq_id == 4'h0, "R11 modem next", irq_id, 0);
      msr_change = 0; tick();
      chk(irq_id == 4'h8, "R11 xoff next", irq_id, 8);
      xoff_rcvd = 0; tick();
      chk(irq_id == 4'hA, "R11 rts last", irq_id, 10);
      quiet(); pulse_rd(); tick();

      // R12 registered output timing
      wr_en(8'h04); tick();
      lsr_err = 4'h1; #1;
      chk(irq == 0, "R12 not before edge", irq, 0);
      @(negedge clk);
      chk(irq == 1 && irq_id == 4'h6, "R12 after edge", irq, 1);
      quiet(); tick(2);

      finish_run();
   end
endmodule